// File: doc/BRIEF.md
# Bipolar Line Code Violation Detector

This block sits behind the slicer of a ternary line receiver. Each received symbol arrives as a pair of pulse flags: one flag for a positive mark and one for a negative mark. A bit strobe qualifies the pair. The block judges every qualified symbol against the line code chosen by a two-bit select, which may be plain AMI, HDB3 or B8ZS. When the symbol breaks that code, the block raises a registered error pulse one clock later.

In HDB3 and B8ZS the transmitter inserts deliberate polarity violations to replace long zero strings. The detector tracks the polarity of the last mark and a three-symbol zero history. For HDB3 it also tracks the polarity of the last accepted violation, and for B8ZS it steps through the eight-symbol substitution. Violations that form a legal substitution are therefore not reported.

An optional zero-run check adds one error for each run of zeros that passes a limit set by the line code. A downstream counter or alarm stage consumes the pulse train.

Top module: `lcv_detect`

## Requirements
- R1: `cv_err` is low after reset. It is high for exactly the one clock that follows a strobed symbol judged in error, and low in every clock that does not follow a strobe.
- R2: While `bit_en` is low, the symbol flags are ignored. They raise no error and change no tracked polarity or zero history.
- R3: A strobed symbol with both `pos_in` and `neg_in` high is an error in every code. It does not change the remembered polarity of the last mark.
- R4: With `code_sel` = 00 (AMI), a mark with the same polarity as the previous mark is an error. The first mark after reset is never an error.
- R5: With `code_sel` = 01 or 11 (HDB3), a same-polarity mark is accepted only when the two symbols before it are zeros and its polarity differs from that of the last accepted violation. No polarity requirement applies before the first accepted violation. Any other same-polarity mark is an error.
- R6: With `code_sel` = 10 (B8ZS), a same-polarity mark preceded by three zeros opens a substitution. The next four symbols must be, in order: an alternating mark, a zero, a same-polarity mark, and an alternating mark. A substitution completed in that way raises no error.
- R7: In B8ZS, the first symbol that departs from an open substitution raises one error and closes it. A same-polarity mark not preceded by three zeros is an error.
- R8: With `zchk_en` high, a zero run raises one error on the zero that makes it longer than the limit, and no further error until a mark ends the run. The limit is 15 for AMI, 7 for B8ZS and 3 for HDB3.
- R9: With `zchk_en` low, zero runs of any length raise no error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_en | input | 1 | Strobe qualifying the current symbol |
| pos_in | input | 1 | Positive mark flag |
| neg_in | input | 1 | Negative mark flag |
| code_sel | input | 2 | 00 AMI, 01 or 11 HDB3, 10 B8ZS |
| zchk_en | input | 1 | Enables the zero-run check |
| cv_err | output | 1 | One-cycle error pulse |

## Verification
Every verdict is registered once, so the pulse for a symbol strobed at one rising edge is visible only during the clock that follows that edge. The bench changes inputs on falling edges, strobes one symbol at a time, and reads `cv_err` on the falling edge right after the strobe edge. Where R1 asks it to, the bench reads `cv_err` again one clock later to confirm that the pulse has ended. For a broken B8ZS substitution, the error is expected at the deviating symbol rather than at the violation that opened the substitution.

// File: rtl/lcv_pkg.sv
// Shared types for the line code violation detector.
package lcv_pkg;

    // Line code select values; 2'b11 is decoded as HDB3.
    typedef enum logic [1:0] {
        LC_AMI  = 2'b00,
        LC_HDB3 = 2'b01,
        LC_B8ZS = 2'b10,
        LC_HDB3B = 2'b11
    } line_code_e;

    // Position inside an open eight-zero substitution (after its first violation).
    typedef enum logic [2:0] {
        S_IDLE = 3'd0,
        S_B1   = 3'd1,
        S_Z    = 3'd2,
        S_V2   = 3'd3,
        S_B2   = 3'd4
    } b8_step_e;

    // True for both select values that choose HDB3.
    function automatic logic is_hdb_code(input logic [1:0] c);
        return c[0];
    endfunction

endpackage

// File: rtl/lcv_history.sv
// Symbol history: remembers polarity of the last mark and whether each of
// the last HIST_DEPTH strobed symbols was a zero (bit 0 = most recent).
// Assumes a symbol with both flags set is neither a mark nor a zero.
module lcv_history #(
    parameter int HIST_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  pos_in,
    input  logic                  neg_in,
    output logic [HIST_DEPTH-1:0] zero_hist,
    output logic                  last_pol,
    output logic                  pol_valid
);

    logic is_mark;
    logic is_zero;

    assign is_mark = pos_in ^ neg_in;
    assign is_zero = !pos_in && !neg_in;

    // Shift the zero flag in and capture the polarity of each mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            zero_hist <= '0;
            last_pol  <= 1'b0;
            pol_valid <= 1'b0;
        end else if (bit_en) begin
            zero_hist <= {zero_hist[HIST_DEPTH-2:0], is_zero};
            if (is_mark) begin
                last_pol  <= pos_in;
                pol_valid <= 1'b1;
            end
        end
    end

    // R4: a strobed mark becomes the polarity reference.
    a_r4_pol_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && is_mark) |=> (pol_valid && (last_pol == $past(pos_in))));

endmodule

// File: rtl/lcv_zero_run.sv
// Zero-run counter: counts consecutive strobed zeros, saturating one past the
// code-dependent limit, and flags the zero that first exceeds the limit.
// Assumes CNT_W holds the largest limit plus one.
module lcv_zero_run #(
    parameter int CNT_W   = 5,
    parameter int AMI_LIM = 15,
    parameter int HDB_LIM = 3,
    parameter int B8_LIM  = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       is_zero,
    input  logic [1:0] code_sel,
    output logic       exz_hit
);
    import lcv_pkg::*;

    localparam logic [CNT_W-1:0] AMI_L = CNT_W'(AMI_LIM);
    localparam logic [CNT_W-1:0] HDB_L = CNT_W'(HDB_LIM);
    localparam logic [CNT_W-1:0] B8_L  = CNT_W'(B8_LIM);

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] run_q;

    // Pick the run limit for the selected code.
    always_comb begin
        if (code_sel == LC_AMI)       limit = AMI_L;
        else if (code_sel == LC_B8ZS) limit = B8_L;
        else                          limit = HDB_L;
    end

    assign exz_hit = bit_en && is_zero && (run_q == limit);

    // Count zeros, clear on any non-zero symbol, hold once past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (bit_en) begin
            if (!is_zero)           run_q <= '0;
            else if (run_q <= limit) run_q <= run_q + 1'b1;
        end
    end

    // R8: one hit per run, never on two strobes in a row.
    a_r8_hit_once: assert property (@(posedge clk) disable iff (!rst_n)
        exz_hit |=> !exz_hit);

endmodule

// File: rtl/lcv_judge.sv
// Violation judge: decides whether a strobed mark that repeats the last
// polarity is legal for the selected code. AMI rejects all of them; HDB3
// accepts one after two zeros with alternating violation polarity; B8ZS
// accepts one after three zeros and then walks the rest of the substitution.
// Assumes HIST_DEPTH >= 3 and that a broken substitution is reported on the
// symbol where it departs from the expected pattern.
module lcv_judge #(
    parameter int HIST_DEPTH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bit_en,
    input  logic                  pos_in,
    input  logic                  neg_in,
    input  logic [1:0]            code_sel,
    input  logic [HIST_DEPTH-1:0] zero_hist,
    input  logic                  last_pol,
    input  logic                  pol_valid,
    output logic                  viol_err
);
    import lcv_pkg::*;

    logic      is_mark;
    logic      is_zero;
    logic      bpv;
    logic      alt_mark;
    logic      hdb_ok;
    logic      b8_start;
    logic      last_vpol;
    logic      vpol_valid;
    b8_step_e  step_q;
    b8_step_e  step_n;

    assign is_mark  = pos_in ^ neg_in;
    assign is_zero  = !pos_in && !neg_in;
    assign bpv      = is_mark && pol_valid && (pos_in == last_pol);
    assign alt_mark = is_mark && !bpv;
    assign hdb_ok   = bpv && zero_hist[0] && zero_hist[1]
                      && (!vpol_valid || (pos_in != last_vpol));
    assign b8_start = bpv && zero_hist[0] && zero_hist[1] && zero_hist[2];

    // Verdict for the current symbol and next substitution step.
    always_comb begin
        viol_err = 1'b0;
        step_n   = step_q;
        if (bit_en) begin
            if (code_sel == LC_AMI) begin
                viol_err = bpv;
                step_n   = S_IDLE;
            end else if (code_sel == LC_B8ZS) begin
                case (step_q)
                    S_IDLE: begin
                        if (bpv) begin
                            if (b8_start) step_n = S_B1;
                            else          viol_err = 1'b1;
                        end
                    end
                    S_B1: begin
                        if (alt_mark) step_n = S_Z;
                        else begin viol_err = 1'b1; step_n = S_IDLE; end
                    end
                    S_Z: begin
                        if (is_zero) step_n = S_V2;
                        else begin viol_err = 1'b1; step_n = S_IDLE; end
                    end
                    S_V2: begin
                        if (bpv) step_n = S_B2;
                        else begin viol_err = 1'b1; step_n = S_IDLE; end
                    end
                    S_B2: begin
                        if (!alt_mark) viol_err = 1'b1;
                        step_n = S_IDLE;
                    end
                    default: step_n = S_IDLE;
                endcase
            end else begin
                viol_err = bpv && !hdb_ok;
                step_n   = S_IDLE;
            end
        end
    end

    // Register the substitution step.
    always_ff @(posedge clk) begin
        if (!rst_n) step_q <= S_IDLE;
        else        step_q <= step_n;
    end

    // Remember the polarity of the last accepted HDB3 violation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_vpol  <= 1'b0;
            vpol_valid <= 1'b0;
        end else if (bit_en && is_hdb_code(code_sel) && hdb_ok) begin
            last_vpol  <= pos_in;
            vpol_valid <= 1'b1;
        end
    end

    // R6: the substitution walk only advances on a strobe.
    a_r6_step_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(step_q));

endmodule

// File: rtl/lcv_detect.sv
// Line code violation detector top: combines the symbol history, the
// violation judge and the zero-run counter into one registered error pulse.
// Assumes bit_en marks each received symbol for exactly one clock.
module lcv_detect #(
    parameter int HIST_DEPTH = 3,
    parameter int CNT_W      = 5,
    parameter int AMI_LIM    = 15,
    parameter int HDB_LIM    = 3,
    parameter int B8_LIM     = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       pos_in,
    input  logic       neg_in,
    input  logic [1:0] code_sel,
    input  logic       zchk_en,
    output logic       cv_err
);

    logic [HIST_DEPTH-1:0] zero_hist;
    logic                  last_pol;
    logic                  pol_valid;
    logic                  viol_err;
    logic                  exz_hit;
    logic                  both_set;
    logic                  sym_zero;
    logic                  err_d;

    assign both_set = pos_in && neg_in;
    assign sym_zero = !pos_in && !neg_in;

    lcv_history #(.HIST_DEPTH(HIST_DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .pos_in(pos_in), .neg_in(neg_in),
        .zero_hist(zero_hist), .last_pol(last_pol), .pol_valid(pol_valid)
    );

    lcv_judge #(.HIST_DEPTH(HIST_DEPTH)) u_judge (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en),
        .pos_in(pos_in), .neg_in(neg_in), .code_sel(code_sel),
        .zero_hist(zero_hist), .last_pol(last_pol), .pol_valid(pol_valid),
        .viol_err(viol_err)
    );

    lcv_zero_run #(
        .CNT_W(CNT_W), .AMI_LIM(AMI_LIM), .HDB_LIM(HDB_LIM), .B8_LIM(B8_LIM)
    ) u_zrun (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .is_zero(sym_zero),
        .code_sel(code_sel), .exz_hit(exz_hit)
    );

    assign err_d = bit_en && (both_set || viol_err || (zchk_en && exz_hit));

    // Register the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) cv_err <= 1'b0;
        else        cv_err <= err_d;
    end

    // R1: a pulse only follows a strobed symbol.
    a_r1_err_follows_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        cv_err |-> $past(bit_en));

    // R2: no strobe, no pulse.
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> !cv_err);

    // R3: both flags set always yields a pulse.
    a_r3_both_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && pos_in && neg_in) |=> cv_err);

endmodule

// File: tb/tb_lcv_detect.sv
module tb_lcv_detect;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       pos_in = 1'b0;
    logic       neg_in = 1'b0;
    logic [1:0] code_sel = 2'b00;
    logic       zchk_en = 1'b0;
    logic       cv_err;

    int n_vec = 0;
    int n_bad = 0;

    lcv_detect dut (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .pos_in(pos_in),
        .neg_in(neg_in), .code_sel(code_sel), .zchk_en(zchk_en), .cv_err(cv_err)
    );

    always #4 clk = ~clk;

    // {reset_before, code, zchk, pos, neg, expected}
    localparam int NV = 58;
    localparam logic [6:0] VEC [0:NV-1] = '{
        // AMI (R4, R3)
        7'b1_00_0_10_0, 7'b0_00_0_01_0, 7'b0_00_0_00_0, 7'b0_00_0_10_0,
        7'b0_00_0_10_1, 7'b0_00_0_01_0, 7'b0_00_0_11_1, 7'b0_00_0_10_0,
        // HDB3 (R5)
        7'b1_01_0_10_0, 7'b0_01_0_00_0, 7'b0_01_0_00_0, 7'b0_01_0_00_0,
        7'b0_01_0_10_0, 7'b0_01_0_01_0, 7'b0_01_0_00_0, 7'b0_01_0_00_0,
        7'b0_01_0_01_0, 7'b0_01_0_10_0, 7'b0_01_0_00_0, 7'b0_01_0_00_0,
        7'b0_01_0_00_0, 7'b0_01_0_10_0, 7'b0_01_0_01_0, 7'b0_01_0_01_1,
        7'b0_01_0_00_0, 7'b0_01_0_00_0, 7'b0_01_0_10_0, 7'b0_01_0_00_0,
        7'b0_01_0_00_0, 7'b0_01_0_10_1,
        // B8ZS (R6, R7)
        7'b1_10_0_10_0,
        7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_10_0,
        7'b0_10_0_01_0, 7'b0_10_0_00_0, 7'b0_10_0_01_0, 7'b0_10_0_10_0,
        7'b0_10_0_01_0,
        7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_01_0,
        7'b0_10_0_10_0, 7'b0_10_0_00_0, 7'b0_10_0_10_0, 7'b0_10_0_01_0,
        7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_01_0,
        7'b0_10_0_00_1,
        7'b0_10_0_10_0, 7'b0_10_0_10_1,
        7'b0_10_0_00_0, 7'b0_10_0_00_0, 7'b0_10_0_10_1
    };

    task automatic chk(input string tag, input logic got, input logic exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: cv_err=%0b expected %0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_en = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Strobe one symbol; result is read on the falling edge after the strobe edge.
    task automatic strobe(input logic p, input logic n, output logic got);
        @(negedge clk);
        pos_in = p; neg_in = n; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; pos_in = 1'b0; neg_in = 1'b0;
        got = cv_err;
    endtask

    task automatic zero_run(input logic [1:0] c, input logic z, input int n, input int lim);
        logic g;
        code_sel = c; zchk_en = z;
        do_reset();
        strobe(1'b1, 1'b0, g);
        for (int k = 1; k <= n; k++) begin
            strobe(1'b0, 1'b0, g);
            chk(z ? "R8 zero run" : "R9 check off", g, z && (k == lim + 1));
        end
        strobe(1'b0, 1'b1, g);
        chk(z ? "R8 run end" : "R9 run end", g, 1'b0);
    endtask

    initial begin : watchdog
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: expired, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin : main
        logic [6:0] v;
        logic       g;
        string      tag;

        // R1: reset state
        do_reset();
        @(negedge clk);
        chk("R1 reset", cv_err, 1'b0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            v = VEC[i];
            code_sel = v[5:4];
            zchk_en  = v[3];
            if (v[6]) do_reset();
            strobe(v[2], v[1], g);
            if (v[2] && v[1])       tag = "R3 both flags";
            else if (v[5:4] == 2'b00) tag = "R4 AMI";
            else if (v[4])          tag = "R5 HDB3";
            else                    tag = "R6_R7 B8ZS";
            chk(tag, g, v[0]);
        end

        // R2: unstrobed flags ignored
        code_sel = 2'b00; zchk_en = 1'b0;
        do_reset();
        strobe(1'b1, 1'b0, g);
        @(negedge clk);
        pos_in = 1'b0; neg_in = 1'b1;
        repeat (3) @(negedge clk);
        pos_in = 1'b1; neg_in = 1'b1;
        repeat (3) @(negedge clk);
        chk("R2 idle flags", cv_err, 1'b0);
        strobe(1'b0, 1'b1, g);
        chk("R2 polarity kept", g, 1'b0);

        // R1: pulse lasts one clock
        strobe(1'b0, 1'b1, g);
        chk("R1 pulse", g, 1'b1);
        @(negedge clk);
        chk("R1 pulse end", cv_err, 1'b0);

        // R3: both flags leave polarity unchanged (last mark negative)
        strobe(1'b1, 1'b1, g);
        chk("R3 both flags", g, 1'b1);
        strobe(1'b1, 1'b0, g);
        chk("R3 polarity kept", g, 1'b0);

        // R5: select value 11 behaves as HDB3
        code_sel = 2'b11;
        do_reset();
        strobe(1'b1, 1'b0, g);
        strobe(1'b0, 1'b0, g);
        strobe(1'b0, 1'b0, g);
        strobe(1'b1, 1'b0, g);
        chk("R5 code 11", g, 1'b0);

        // R8 / R9: zero-run limits
        zero_run(2'b00, 1'b1, 20, 15);
        zero_run(2'b10, 1'b1, 10, 7);
        zero_run(2'b01, 1'b1, 6, 3);
        zero_run(2'b00, 1'b0, 20, 15);
        zero_run(2'b10, 1'b0, 10, 7);

        // R8: a new run after a mark hits again
        code_sel = 2'b10; zchk_en = 1'b1;
        for (int k = 1; k <= 9; k++) begin
            strobe(1'b0, 1'b0, g);
            chk("R8 second run", g, k == 8);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule